// File: doc/BRIEF.md
# Masked Vector Execute Unit

This unit owns a bank of vector registers and executes integer vector instructions on it, one element per clock cycle. A single issue port delivers an opcode, a destination and two source register numbers, and a 64-bit scalar operand. An instruction accepted while the unit is idle is stepped across the elements selected by the current vector length, and each result is written back to the destination register. Elements at or beyond the vector length keep their previous contents.

A vector length register sets how many elements each instruction covers. It is loaded by a dedicated opcode from the low address-sized bits of the scalar operand, and it is clamped to the register depth. A per-element mask register is filled by compare-against-zero instructions. A merge instruction uses the mask to choose, element by element, between its two sources. Software reads the register contents back through a read port while the unit is idle. It observes the length and the mask directly on output ports.

Top module: `vec_exec_unit`

## Requirements
- R1: The bank holds 8 registers of 64 elements of 64 bits. While busy is low, setting rd_vreg and rd_elem before a clock edge presents that element on rd_data after the edge.
- R2: Opcode 0 (set length) is executed in the cycle it is issued while idle and does not raise busy. The length becomes the value of issue_scalar[23:0], or 64 when that value exceeds 64. Scalar bits 63:24 are ignored. After reset the length is 64 and the mask is all zeros.
- R3: While the length is 0, every vector opcode (1 to 12) is a no-op: busy stays low and no register or mask bit changes.
- R4: A vector opcode issued while idle with length L > 0 holds busy high for exactly L+1 cycles, starting the cycle after issue. Any issue, including opcode 0, made while busy is high is ignored.
- R5: Opcodes 1 (dst=a+b), 2 (dst=a+scalar), 11 (dst=scalar) and 12 (dst=scalar+i, with i the element index) compute 64-bit modular results per element.
- R6: Opcodes 3 (a AND b), 4 (a OR b), 5 (a XOR b), 6 (a shifted left by scalar[5:0]) and 7 (a logically shifted right by scalar[5:0]) compute per element.
- R7: Opcode 8 sets mask bit i to 1 when element i of source a equals zero, and to 0 otherwise. Opcode 9 sets the opposite value. Both write no register. Mask bits at or beyond the length keep their value.
- R8: Opcode 10 (merge) writes element i from source a when mask bit i is 1, and from source b when it is 0.
- R9: Elements with index at or beyond the length keep their old destination contents.
- R10: Opcodes 13 to 15 are ignored: busy stays low and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Instruction present on the issue port |
| issue_op | input | 4 | Opcode |
| issue_vd | input | 3 | Destination register number |
| issue_va | input | 3 | First source register number |
| issue_vb | input | 3 | Second source register number |
| issue_scalar | input | 64 | Scalar operand, also the length source |
| rd_vreg | input | 3 | Read-back register number |
| rd_elem | input | 6 | Read-back element index |
| busy | output | 1 | Instruction in progress; issues are ignored |
| vlen | output | 7 | Current vector length |
| mask | output | 64 | Current vector mask |
| rd_data | output | 64 | Read-back element value |

## Verification
The assertions assume that issue_op only carries values of 0 to 15 that the stimulus actually drives, and that nothing other than the issue port changes the length or the mask. They also assume that an instruction is either accepted while idle or dropped, never queued. The bench drives the issue port for exactly one cycle per instruction. It then waits for busy to fall before it reads back, so it samples the read port only while idle. It also deliberately issues into a busy window to exercise the drop path. Random lengths run from 0 to 70, so the zero and clamped lengths come up alongside the directed cases.

// File: rtl/vxu_pkg.sv
package vxu_pkg;

  typedef enum logic [3:0] {
    OP_SETVL  = 4'd0,
    OP_VADD   = 4'd1,
    OP_VADDS  = 4'd2,
    OP_VAND   = 4'd3,
    OP_VOR    = 4'd4,
    OP_VXOR   = 4'd5,
    OP_VSLL   = 4'd6,
    OP_VSRL   = 4'd7,
    OP_VTSTZ  = 4'd8,
    OP_VTSTNZ = 4'd9,
    OP_VMERGE = 4'd10,
    OP_VBCAST = 4'd11,
    OP_VIOTA  = 4'd12
  } vop_e;

  function automatic logic is_vector_op(vop_e op);
    return (op >= OP_VADD) && (op <= OP_VIOTA);
  endfunction

endpackage

// File: rtl/vxu_regbank.sv
module vxu_regbank #(
  parameter int W     = 64,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/vxu_seq.sv
module vxu_seq #(
  parameter int NELEM = 64,
  localparam int IW   = $clog2(NELEM),
  localparam int VLW  = IW + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [VLW-1:0] start_vl,
  output logic           run,
  output logic [IW-1:0]  cnt,
  output logic           s1_valid,
  output logic [IW-1:0]  s1_idx,
  output logic           busy
);

  logic [IW-1:0] last_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      cnt      <= '0;
      last_idx <= '0;
      s1_valid <= 1'b0;
      s1_idx   <= '0;
    end else begin
      s1_valid <= run;
      s1_idx   <= cnt;
      if (start) begin
        run      <= 1'b1;
        cnt      <= '0;
        last_idx <= IW'(start_vl - VLW'(1));
      end else if (run) begin
        if (cnt == last_idx) run <= 1'b0;
        else                 cnt <= cnt + IW'(1);
      end
    end
  end

  assign busy = run | s1_valid;

endmodule

// File: rtl/vxu_alu.sv
module vxu_alu
  import vxu_pkg::*;
#(
  parameter int W     = 64,
  parameter int NELEM = 64,
  localparam int IW   = $clog2(NELEM),
  localparam int SHW  = $clog2(W)
) (
  input  vop_e          op,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic [W-1:0]  scalar,
  input  logic [IW-1:0] idx,
  input  logic          mask_bit,
  output logic [W-1:0]  res,
  output logic          reg_we,
  output logic          mask_we,
  output logic          mask_val
);

  always_comb begin
    res      = '0;
    reg_we   = 1'b1;
    mask_we  = 1'b0;
    mask_val = 1'b0;
    unique case (op)
      OP_VADD:   res = a + b;
      OP_VADDS:  res = a + scalar;
      OP_VAND:   res = a & b;
      OP_VOR:    res = a | b;
      OP_VXOR:   res = a ^ b;
      OP_VSLL:   res = a << scalar[SHW-1:0];
      OP_VSRL:   res = a >> scalar[SHW-1:0];
      OP_VMERGE: res = mask_bit ? a : b;
      OP_VBCAST: res = scalar;
      OP_VIOTA:  res = scalar + W'(idx);
      OP_VTSTZ: begin
        reg_we   = 1'b0;
        mask_we  = 1'b1;
        mask_val = (a == '0);
      end
      OP_VTSTNZ: begin
        reg_we   = 1'b0;
        mask_we  = 1'b1;
        mask_val = (a != '0);
      end
      default:   reg_we = 1'b0;
    endcase
  end

endmodule

// File: rtl/vec_exec_unit.sv
module vec_exec_unit
  import vxu_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int NELEM  = 64,
  parameter int W      = 64,
  parameter int ADDR_W = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     issue_valid,
  input  logic [3:0]               issue_op,
  input  logic [$clog2(NREG)-1:0]  issue_vd,
  input  logic [$clog2(NREG)-1:0]  issue_va,
  input  logic [$clog2(NREG)-1:0]  issue_vb,
  input  logic [W-1:0]             issue_scalar,
  input  logic [$clog2(NREG)-1:0]  rd_vreg,
  input  logic [$clog2(NELEM)-1:0] rd_elem,
  output logic                     busy,
  output logic [$clog2(NELEM):0]   vlen,
  output logic [NELEM-1:0]         mask,
  output logic [W-1:0]             rd_data
);

  localparam int RW    = $clog2(NREG);
  localparam int IW    = $clog2(NELEM);
  localparam int VLW   = IW + 1;
  localparam int DEPTH = NREG * NELEM;
  localparam int AW    = $clog2(DEPTH);
  localparam logic [ADDR_W-1:0] MAXVL_A = ADDR_W'(NELEM);

  vop_e          op_in;
  vop_e          op_q;
  logic [RW-1:0] vd_q, va_q, vb_q;
  logic [W-1:0]  sc_q;
  logic [VLW-1:0] vlen_q;
  logic [NELEM-1:0] mask_q;
  logic          accept_vec, accept_setvl;
  logic [ADDR_W-1:0] len_req;

  logic          run, s1_valid;
  logic [IW-1:0] cnt, s1_idx;

  logic [AW-1:0] raddr [2];
  logic [W-1:0]  rdata [2];
  logic [AW-1:0] waddr;
  logic [W-1:0]  alu_res;
  logic          alu_we, alu_mask_we, alu_mask_val;

  assign op_in        = vop_e'(issue_op);
  assign accept_vec   = issue_valid && !busy && is_vector_op(op_in) && (vlen_q != '0);
  assign accept_setvl = issue_valid && !busy && (op_in == OP_SETVL);
  assign len_req      = issue_scalar[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= OP_SETVL;
      vd_q   <= '0;
      va_q   <= '0;
      vb_q   <= '0;
      sc_q   <= '0;
      vlen_q <= VLW'(NELEM);
    end else begin
      if (accept_vec) begin
        op_q <= op_in;
        vd_q <= issue_vd;
        va_q <= issue_va;
        vb_q <= issue_vb;
        sc_q <= issue_scalar;
      end
      if (accept_setvl)
        vlen_q <= (len_req > MAXVL_A) ? VLW'(NELEM) : VLW'(len_req);
    end
  end

  vxu_seq #(.NELEM(NELEM)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (accept_vec),
    .start_vl (vlen_q),
    .run      (run),
    .cnt      (cnt),
    .s1_valid (s1_valid),
    .s1_idx   (s1_idx),
    .busy     (busy)
  );

  // port 0 serves source a while stepping and the read-back port otherwise
  assign raddr[0] = run ? {va_q, cnt} : {rd_vreg, rd_elem};
  assign raddr[1] = {vb_q, cnt};
  assign waddr    = {vd_q, s1_idx};

  for (genvar gi = 0; gi < 2; gi++) begin : g_copy
    vxu_regbank #(.W(W), .DEPTH(DEPTH)) u_bank (
      .clk   (clk),
      .we    (s1_valid && alu_we),
      .waddr (waddr),
      .wdata (alu_res),
      .raddr (raddr[gi]),
      .rdata (rdata[gi])
    );
  end

  vxu_alu #(.W(W), .NELEM(NELEM)) u_alu (
    .op       (op_q),
    .a        (rdata[0]),
    .b        (rdata[1]),
    .scalar   (sc_q),
    .idx      (s1_idx),
    .mask_bit (mask_q[s1_idx]),
    .res      (alu_res),
    .reg_we   (alu_we),
    .mask_we  (alu_mask_we),
    .mask_val (alu_mask_val)
  );

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else if (s1_valid && alu_mask_we) mask_q[s1_idx] <= alu_mask_val;
  end

  assign vlen    = vlen_q;
  assign mask    = mask_q;
  assign rd_data = rdata[0];

endmodule

// File: rtl/vxu_checker.sv
module vxu_checker #(
  parameter int NELEM = 64,
  localparam int VLW  = $clog2(NELEM) + 1
) (
  input logic           clk,
  input logic           rst,
  input logic           issue_valid,
  input logic [3:0]     issue_op,
  input logic           busy,
  input logic [VLW-1:0] vlen,
  input logic [NELEM-1:0] mask
);

  logic          vec_issue;
  logic [VLW:0]  busy_run;

  assign vec_issue = issue_valid && !busy && (issue_op >= 4'd1) && (issue_op <= 4'd12);

  always_ff @(posedge clk) begin
    if (rst)       busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1'b1;
    else           busy_run <= '0;
  end

  AST_VLEN_CAPPED: assert property (@(posedge clk) disable iff (rst)
    vlen <= VLW'(NELEM)); // R2

  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
    vec_issue && (vlen != '0) |=> busy); // R4

  AST_ZERO_LEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    vec_issue && (vlen == '0) |=> !busy); // R3

  AST_VLEN_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(vlen)); // R4

  AST_MASK_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(mask)); // R7

  AST_UNUSED_OP_IDLE: assert property (@(posedge clk) disable iff (rst)
    issue_valid && !busy && (issue_op >= 4'd13) |=> !busy); // R10

  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    busy |-> busy_run <= (VLW+1)'(NELEM)); // R4

endmodule

bind vec_exec_unit vxu_checker #(.NELEM(NELEM)) u_vxu_checker (.*);

// File: tb/vec_exec_unit_bench.sv
`timescale 1ns/1ps
module vec_exec_unit_bench;
  import vxu_pkg::*;

  localparam int NREG = 8, NELEM = 64, W = 64;

  logic clk = 1'b0, rst = 1'b1;
  logic issue_valid = 1'b0;
  logic [3:0] issue_op = '0;
  logic [2:0] issue_vd = '0, issue_va = '0, issue_vb = '0, rd_vreg = '0;
  logic [63:0] issue_scalar = '0;
  logic [5:0] rd_elem = '0;
  logic busy;
  logic [6:0] vlen;
  logic [63:0] mask, rd_data;

  vec_exec_unit u_vec_exec_unit (.*);

  always #2 clk = ~clk;

  int n_chk = 0, n_err = 0;
  logic [63:0] mdl [NREG][NELEM];
  logic [63:0] mmask = '0;
  int mvl = 64;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit vec_op(input int op);
    return op >= 1 && op <= 12;
  endfunction

  task automatic model_apply(input int op, input int vd, input int va, input int vb, input logic [63:0] sc);
    logic [63:0] a, b;
    if (op == 0) begin
      mvl = (int'(sc[23:0]) > 64) ? 64 : int'(sc[23:0]);
    end else if (vec_op(op)) begin
      for (int i = 0; i < mvl; i++) begin
        a = mdl[va][i];
        b = mdl[vb][i];
        case (op)
          1:  mdl[vd][i] = a + b;
          2:  mdl[vd][i] = a + sc;
          3:  mdl[vd][i] = a & b;
          4:  mdl[vd][i] = a | b;
          5:  mdl[vd][i] = a ^ b;
          6:  mdl[vd][i] = a << sc[5:0];
          7:  mdl[vd][i] = a >> sc[5:0];
          8:  mmask[i] = (a == 0);
          9:  mmask[i] = (a != 0);
          10: mdl[vd][i] = mmask[i] ? a : b;
          11: mdl[vd][i] = sc;
          default: mdl[vd][i] = sc + 64'(i);
        endcase
      end
    end
  endtask

  task automatic check_reg(input int r, input string tag);
    logic [63:0] bad_act = '0, bad_exp = '0;
    bit ok = 1'b1;
    for (int e = 0; e < NELEM; e++) begin
      @(negedge clk);
      rd_vreg = 3'(r);
      rd_elem = 6'(e);
      @(negedge clk);
      if (ok && rd_data !== mdl[r][e]) begin
        ok = 1'b0;
        bad_act = rd_data;
        bad_exp = mdl[r][e];
      end
    end
    chk(ok, tag, bad_act, bad_exp);
  endtask

  task automatic drive(input int op, input int vd, input int va, input int vb, input logic [63:0] sc);
    issue_valid  = 1'b1;
    issue_op     = 4'(op);
    issue_vd     = 3'(vd);
    issue_va     = 3'(va);
    issue_vb     = 3'(vb);
    issue_scalar = sc;
  endtask

  // issue one instruction, measure busy, update model, check state
  task automatic run_op(input int op, input int vd, input int va, input int vb,
                        input logic [63:0] sc, input string tag);
    int n = 0;
    int exp_busy;
    @(negedge clk);
    drive(op, vd, va, vb, sc);
    @(negedge clk);
    issue_valid = 1'b0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
    exp_busy = (vec_op(op) && mvl > 0) ? mvl + 1 : 0;
    chk(n == exp_busy, {tag, " R4 busy length"}, 64'(n), 64'(exp_busy));
    model_apply(op, vd, va, vb, sc);
    chk(vlen == 7'(mvl), {tag, " R2 length"}, 64'(vlen), 64'(mvl));
    chk(mask == mmask, {tag, " R7 mask"}, mask, mmask);
    check_reg(vd, {tag, " register"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] sc;
    int op, n;
    void'($urandom(32'd7351));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R2 reset state
    chk(busy == 1'b0, "R2 reset busy", 64'(busy), 64'd0);
    chk(vlen == 7'd64, "R2 reset length", 64'(vlen), 64'd64);
    chk(mask == '0, "R2 reset mask", mask, 64'd0);

    // R5 R1 fill every register with an index ramp
    for (int r = 0; r < NREG; r++)
      run_op(12, r, 0, 0, {$urandom, $urandom}, "R5 R1 iota fill");

    // R2 clamp and ignored upper bits
    run_op(0, 1, 0, 0, 64'd100, "R2 clamp 100");
    run_op(0, 1, 0, 0, 64'h0000_0001_0000_0005, "R2 upper bits ignored");
    // R9 tail kept with length 5
    run_op(1, 3, 1, 2, 64'd0, "R9 R5 add short length");
    // R3 zero length no-op
    run_op(0, 1, 0, 0, 64'd0, "R3 set zero");
    run_op(11, 4, 0, 0, 64'hDEAD_BEEF, "R3 broadcast at zero length");
    run_op(9, 4, 4, 0, 64'd0, "R3 test at zero length");
    // R10 unused opcodes
    run_op(0, 1, 0, 0, 64'd64, "R2 set 64");
    run_op(14, 5, 1, 2, 64'd3, "R10 unused opcode");

    // R4 issue while busy is dropped
    @(negedge clk);
    drive(1, 5, 1, 2, 64'd0);
    @(negedge clk);
    drive(11, 6, 0, 0, 64'h1234);
    @(negedge clk);
    drive(0, 0, 0, 0, 64'd3);
    @(negedge clk);
    issue_valid = 1'b0;
    n = 2;
    while (busy) begin
      n++;
      @(negedge clk);
    end
    chk(n == 65, "R4 busy with extra issues", 64'(n), 64'd65);
    model_apply(1, 5, 1, 2, 64'd0);
    chk(vlen == 7'd64, "R4 length unchanged by dropped issue", 64'(vlen), 64'd64);
    check_reg(5, "R4 R5 add full length");
    check_reg(6, "R4 dropped broadcast");

    // R7 compare with zero, partial length
    run_op(11, 7, 0, 0, 64'd0, "R5 broadcast zero");
    run_op(0, 1, 0, 0, 64'd10, "R2 set 10");
    run_op(12, 7, 0, 0, 64'd1, "R9 iota partial");
    run_op(0, 1, 0, 0, 64'd64, "R2 set 64");
    run_op(8, 0, 7, 0, 64'd0, "R7 test zero");
    run_op(0, 1, 0, 0, 64'd8, "R2 set 8");
    run_op(9, 0, 1, 0, 64'd0, "R7 test nonzero partial");
    run_op(0, 1, 0, 0, 64'd64, "R2 set 64");
    // R8 merge
    run_op(10, 2, 1, 3, 64'd0, "R8 merge");
    // R6 shift edges and logic
    run_op(6, 4, 1, 0, 64'd63, "R6 shift left 63");
    run_op(7, 5, 1, 0, 64'hFFC0, "R6 shift right by low bits 0");
    run_op(5, 6, 1, 2, 64'd0, "R6 xor");

    // random mix
    for (int k = 0; k < 70; k++) begin
      op = $urandom_range(0, 15);
      sc = ($urandom_range(0, 3) == 0) ? 64'd0 : {$urandom, $urandom};
      if (op == 0) sc = 64'($urandom_range(0, 70));
      run_op(op, $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7), sc,
             "R5 R6 R7 R8 R9 random");
    end
    for (int r = 0; r < NREG; r++) check_reg(r, "R1 final register contents");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule